// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Register

This block is a parallel register whose every bit is a pair of level-sensitive latches: a master latch and a slave latch. The master latch opens under one of two clocks. The functional clock lets it take the bit's parallel data. The test clock lets it take the scan bit coming from the previous cell. A third clock, the transfer clock, opens the slave latch, which copies the master's content and drives the parallel output.

The two capture sources are selected by which clock is pulsing, not by a select signal in front of the latch. Each cell gates its inputs with two AND terms. As a result, the functional data path has no multiplexer delay added to it.

Cells form a chain: each slave output feeds the scan input of the next cell, and the last slave output is the scan output. To shift the chain by one position, pulse the test clock and then the transfer clock. To capture the parallel word, pulse the functional clock and then the transfer clock.

The clocks must never overlap. The master-side clocks must not be high together, and neither may be high while the transfer clock is high. The reset is active-low and takes effect only through the clocks: while it is low, an open latch loads 0.

Top module: `lssd_scan_register`

## Requirements
- R1: While rst_n is 0, a pulse on func_clk (or test_clk) followed by a pulse on xfer_clk sets every bit of q and scan_out to 0.
- R2: A func_clk pulse followed by an xfer_clk pulse makes q equal to the value d held during the func_clk pulse.
- R3: q changes only while xfer_clk is high; a func_clk or test_clk pulse on its own leaves q unchanged.
- R4: A test_clk pulse followed by an xfer_clk pulse shifts the chain toward higher index: bit 0 takes scan_in, bit i takes the old bit i-1, and scan_out always equals q[WIDTH-1].
- R5: During a scan shift, with func_clk held at 0, the value on d has no effect on q.
- R6: During a functional capture, with test_clk held at 0, the value on scan_in has no effect on q.
- R7: func_clk and test_clk are never high at the same time.
- R8: xfer_clk is never high while func_clk or test_clk is high.
- R9: Once the master-side clock has fallen, a change on d before the xfer_clk pulse does not alter the value that reaches q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, applied through the clocks |
| func_clk | input | 1 | Functional clock, opens master latches to d |
| test_clk | input | 1 | Test clock, opens master latches to the scan chain |
| xfer_clk | input | 1 | Transfer clock, opens slave latches |
| d | input | WIDTH | Parallel functional data |
| scan_in | input | 1 | Serial input to cell 0 |
| q | output | WIDTH | Parallel slave outputs |
| scan_out | output | 1 | Serial output, equal to the last cell's slave |

## Verification
The bench pulses a master-side clock without the transfer clock to catch slave latches that leak through. A flow-through latch would change q early and break R3.

It changes d after func_clk falls and before the transfer pulse. A master latch that stays open past its clock would then pass the late value to q.

It toggles d on every scan shift and toggles scan_in during a capture. A design that ORs both sources without gating would then corrupt the shifted pattern or the captured word.

Finally, it shifts a known pattern in, captures a word, and shifts that word out bit by bit. This checks the shift direction and the position of scan_out at the end of the chain, where a reversed chain shows up at once.

// File: rtl/lssd_pkg.sv
// Package: shared helpers for the level-sensitive scan register.
// Assumes the functional and test clocks are never high together.
package lssd_pkg;
    // Gated capture term: two AND terms, no select line in the data path.
    function automatic logic capture_term(input logic fclk, input logic tclk,
                                          input logic dat, input logic sin);
        return (fclk & dat) | (tclk & sin);
    endfunction
endpackage

// File: rtl/lssd_master_latch.sv
// Master latch: transparent while either master-side clock is high.
// Takes d under the functional clock and sin under the test clock.
// Loads 0 instead when rst_n is low while open.
module lssd_master_latch
    import lssd_pkg::*;
(
    input  logic rst_n,
    input  logic fclk,
    input  logic tclk,
    input  logic d_i,
    input  logic sin_i,
    output logic m_o
);
    logic open_w;
    logic cap_w;

    // Open window and gated data selection.
    always_comb begin
        open_w = fclk | tclk;
        cap_w  = capture_term(fclk, tclk, d_i, sin_i);
    end

    // Level-sensitive storage with synchronous-style active-low clear.
    always_latch begin
        if (open_w) m_o <= rst_n ? cap_w : 1'b0;
    end

    // R2: once the functional clock closes, the master holds the data bit.
    a_r2_master_took_data: assert property (@(negedge fclk) disable iff (!rst_n)
        m_o == d_i) else $error("a_r2_master_took_data");

    // R4: once the test clock closes, the master holds the scan bit.
    a_r4_master_took_scan: assert property (@(negedge tclk) disable iff (!rst_n)
        m_o == sin_i) else $error("a_r4_master_took_scan");
endmodule

// File: rtl/lssd_slave_latch.sv
// Slave latch: transparent while the transfer clock is high.
// Copies the master content, or 0 when rst_n is low.
module lssd_slave_latch (
    input  logic rst_n,
    input  logic xclk,
    input  logic m_i,
    output logic s_o
);
    // Level-sensitive storage driven by the transfer clock.
    always_latch begin
        if (xclk) s_o <= rst_n ? m_i : 1'b0;
    end

    // R3: at the close of the transfer window the slave matches the master.
    a_r3_slave_follows_master: assert property (@(negedge xclk) disable iff (!rst_n)
        s_o == m_i) else $error("a_r3_slave_follows_master");
endmodule

// File: rtl/lssd_cell.sv
// One scan cell: a master latch feeding a slave latch.
// The slave output is both the parallel bit and the scan output.
module lssd_cell (
    input  logic rst_n,
    input  logic fclk,
    input  logic tclk,
    input  logic xclk,
    input  logic d_i,
    input  logic sin_i,
    output logic q_o
);
    logic m_w;

    lssd_master_latch u_mst (
        .rst_n(rst_n), .fclk(fclk), .tclk(tclk),
        .d_i(d_i), .sin_i(sin_i), .m_o(m_w)
    );

    lssd_slave_latch u_slv (
        .rst_n(rst_n), .xclk(xclk), .m_i(m_w), .s_o(q_o)
    );
endmodule

// File: rtl/lssd_scan_register.sv
// Top: WIDTH scan cells chained from bit 0 to bit WIDTH-1.
// Assumes three non-overlapping clocks supplied from outside.
module lssd_scan_register #(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             func_clk,
    input  logic             test_clk,
    input  logic             xfer_clk,
    input  logic [WIDTH-1:0] d,
    input  logic             scan_in,
    output logic [WIDTH-1:0] q,
    output logic             scan_out
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH:0] chain_w;

    // Serial input enters at position 0.
    always_comb chain_w[0] = scan_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        lssd_cell u_cell (
            .rst_n(rst_n), .fclk(func_clk), .tclk(test_clk), .xclk(xfer_clk),
            .d_i(d[i]), .sin_i(chain_w[i]), .q_o(chain_w[i+1])
        );
        // Parallel output bit.
        always_comb q[i] = chain_w[i+1];
    end

    // Serial output is the last slave.
    always_comb scan_out = chain_w[LAST+1];

    // Clock-overlap checks on the external clocks.
    always_comb begin
        if (rst_n) begin
            a_r7_no_func_test_overlap: assert (!(func_clk && test_clk))
                else $error("a_r7_no_func_test_overlap");
            a_r8_no_master_slave_overlap: assert (!((func_clk || test_clk) && xfer_clk))
                else $error("a_r8_no_master_slave_overlap");
        end
    end
endmodule

// File: tb/tb_lssd_scan_register.sv
module tb_lssd_scan_register;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic rst_n = 1'b0, func_clk = 1'b0, test_clk = 1'b0, xfer_clk = 1'b0;
    logic [W-1:0] d = '0;
    logic scan_in = 1'b0;
    logic [W-1:0] q;
    logic scan_out;

    int checks = 0, errors = 0;
    logic [W-1:0] model = '0;
    logic [W-1:0] exp_q[$];
    string tag_q[$];
    event smp;
    bit done = 0;

    lssd_scan_register #(.WIDTH(W)) dut (
        .rst_n(rst_n), .func_clk(func_clk), .test_clk(test_clk), .xfer_clk(xfer_clk),
        .d(d), .scan_in(scan_in), .q(q), .scan_out(scan_out)
    );

    // Monitor: pops expected items and compares q and scan_out.
    initial forever begin
        @(smp);
        while (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (q !== e || scan_out !== e[W-1]) begin
                errors++;
                $display("FAIL %s: q=%h so=%b expected q=%h so=%b", t, q, scan_out, e, e[W-1]);
            end
        end
    end

    task automatic expect_q(input logic [W-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        ->smp;
        #1;
    endtask

    task automatic pulse_f();
        func_clk = 1; #(CLK_PERIOD/2); func_clk = 0; #(CLK_PERIOD/2);
    endtask
    task automatic pulse_t();
        test_clk = 1; #(CLK_PERIOD/2); test_clk = 0; #(CLK_PERIOD/2);
    endtask
    task automatic pulse_x();
        xfer_clk = 1; #(CLK_PERIOD/2); xfer_clk = 0; #(CLK_PERIOD/2);
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD);
        // R1: reset through a capture and a transfer.
        d = 8'hFF; scan_in = 1;
        pulse_f(); pulse_x();
        model = '0;
        expect_q(model, "R1 reset clears");
        rst_n = 1;
        #(CLK_PERIOD);

        // R2: functional capture.
        d = 8'hA5; scan_in = 0;
        pulse_f(); pulse_x();
        model = 8'hA5;
        expect_q(model, "R2 capture A5");

        // R3: master pulse alone leaves q unchanged.
        d = 8'h3C;
        pulse_f();
        expect_q(model, "R3 no transfer, q holds");
        // R9: late d change is not seen.
        d = 8'hFF;
        pulse_x();
        model = 8'h3C;
        expect_q(model, "R9 late d ignored");
        pulse_t();
        expect_q(model, "R3 test pulse alone, q holds");

        // R4/R5: shift in a pattern with d toggling.
        for (int i = 0; i < W; i++) begin
            logic b;
            b = (8'b1101_0010 >> i) & 1'b1;
            scan_in = b;
            d = (i % 2) ? 8'hFF : 8'h00;
            pulse_t(); pulse_x();
            model = {model[W-2:0], b};
            expect_q(model, "R4 R5 shift in");
        end

        // R6: capture with scan_in toggling during the pulse.
        d = 8'h5A; scan_in = 1;
        func_clk = 1; #(CLK_PERIOD/4); scan_in = 0; #(CLK_PERIOD/4);
        func_clk = 0; #(CLK_PERIOD/2);
        pulse_x();
        model = 8'h5A;
        expect_q(model, "R6 scan_in ignored in capture");

        // R4: shift out, scan_out walks the captured word from its top bit.
        for (int i = 0; i < W; i++) begin
            scan_in = 0;
            pulse_t(); pulse_x();
            model = {model[W-2:0], 1'b0};
            expect_q(model, "R4 shift out");
        end

        // R1: reset again via the test clock.
        d = 8'hC3; pulse_f(); pulse_x();
        rst_n = 0;
        pulse_t(); pulse_x();
        model = '0;
        expect_q(model, "R1 reset via test clock");

        #(CLK_PERIOD);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule